// File: doc/BRIEF.md
# Two-Level Address Translation Walker

This block resolves a 32-bit virtual address into a physical address after a translation cache miss. It fetches one entry from a first-level table and, for small pages, one entry from a second-level table. The first-level table sits at the frame given by a directory base input. Each table is one 4 KB page of 1024 four-byte entries. When a first-level entry maps a 4 MB page and the large-page strap is on, the walk ends after the first read.

At the end of a walk the requester gets three results: the physical address, the low twelve flag bits of the final entry, and a fault flag. When the final entry's accessed flag is clear, the walker writes that entry back with the flag set. It also sets the dirty flag when the access is a store and the dirty flag is clear. Memory is reached through a single-outstanding request/acknowledge port. The request is held steady until a one-cycle acknowledge returns, and read data arrives with that acknowledge.

Top module: `ptw_two_level`

## Requirements
- R1: After reset, `walk_done` and `mem_req` are low until a lookup is accepted.
- R2: The first read goes to address {`dir_base`, vaddr[31:22], 2'b00}.
- R3: For a small page, the second read goes to {L1 entry[31:12], vaddr[21:12], 2'b00}. The result is {L2 entry[31:12], vaddr[11:0]}.
- R4: With `big_page_en` high, a present first-level entry with bit 7 set ends the walk after one read. The result is {entry[31:22], vaddr[21:0]}.
- R5: With `big_page_en` low, bit 7 of a first-level entry has no effect and the walk always reads the second level.
- R6: An entry whose bit 0 (present) is clear ends the walk with `walk_fault` high, at either level. No further read or write is issued, and `walk_paddr` is zero.
- R7: When the final entry's bit 5 (accessed) is clear, the entry is written back to its own address with bit 5 set. When it is set and no dirty update is due, no write is issued.
- R8: For a store (`lookup_write` high) whose final entry has bit 6 (dirty) clear, the write-back also sets bit 6. A load never changes bit 6.
- R9: Bits 11:9 of an entry do not change the walk. They are kept unchanged in the write-back and in `walk_flags`.
- R10: A lookup is taken only while the walker is idle, and lookups raised during a walk are dropped. `walk_done` is high for exactly one cycle per walk, and `walk_flags` carries the final entry as updated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| lookup_valid | input | 1 | Start a walk (taken when idle) |
| lookup_vaddr | input | 32 | Virtual address to translate |
| lookup_write | input | 1 | Access is a store |
| big_page_en | input | 1 | Strap: honour 4 MB first-level mappings |
| dir_base | input | 20 | Frame number of the first-level table |
| mem_req | output | 1 | Memory request pending |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 32 | Byte address of the entry |
| mem_wdata | output | 32 | Entry value to write |
| mem_ack | input | 1 | One-cycle completion of the pending request |
| mem_rdata | input | 32 | Read data, valid with `mem_ack` |
| walk_done | output | 1 | Walk finished (one cycle) |
| walk_fault | output | 1 | Walk hit a non-present entry |
| walk_paddr | output | 32 | Translated physical address |
| walk_flags | output | 12 | Flag bits of the final entry after update |

## Verification
The assertions assume that memory acknowledges only while a request is pending, never more than once per request, and for no longer than one cycle. They also assume that `dir_base` and the strap are stable during a walk. The bench memory model keeps to this. It is a responder that counts a fixed latency from a visible request, drives the acknowledge for one cycle away from the clock edge, and then drops it. The bench changes the base and the strap only between walks.

// File: rtl/ptw_two_level.sv
module ptw_two_level (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        lookup_valid,
  input  logic [31:0] lookup_vaddr,
  input  logic        lookup_write,
  input  logic        big_page_en,
  input  logic [19:0] dir_base,
  output logic        mem_req,
  output logic        mem_we,
  output logic [31:0] mem_addr,
  output logic [31:0] mem_wdata,
  input  logic        mem_ack,
  input  logic [31:0] mem_rdata,
  output logic        walk_done,
  output logic        walk_fault,
  output logic [31:0] walk_paddr,
  output logic [11:0] walk_flags
);
  localparam int BIT_PRES  = 0;
  localparam int BIT_ACC   = 5;
  localparam int BIT_DIRTY = 6;
  localparam int BIT_BIG   = 7;

  typedef enum logic [2:0] {IDLE, READ_L1, READ_L2, UPDATE, DONE} st_t;

  st_t         state;
  logic [31:0] va_q;
  logic        wr_q;
  logic        big_q;
  logic        fault_q;
  logic        large_q;
  logic [31:0] ent;
  logic [31:0] ent_addr;

  logic [31:0] l1_addr, l2_addr;
  logic        need_upd;

  assign l1_addr  = {dir_base, va_q[31:22], 2'b00};
  assign l2_addr  = {ent[31:12], va_q[21:12], 2'b00};
  assign need_upd = !mem_rdata[BIT_ACC] || (wr_q && !mem_rdata[BIT_DIRTY]);

  assign mem_req   = (state == READ_L1) || (state == READ_L2) || (state == UPDATE);
  assign mem_we    = (state == UPDATE);
  assign mem_addr  = (state == READ_L1) ? l1_addr :
                     (state == READ_L2) ? l2_addr : ent_addr;
  assign mem_wdata = ent | (32'(wr_q) << BIT_DIRTY) | (32'd1 << BIT_ACC);

  assign walk_done  = (state == DONE);
  assign walk_fault = fault_q;
  assign walk_flags = ent[11:0];
  assign walk_paddr = fault_q ? 32'd0 :
                      large_q ? {ent[31:22], va_q[21:0]} : {ent[31:12], va_q[11:0]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= IDLE;
      va_q     <= '0;
      wr_q     <= 1'b0;
      big_q    <= 1'b0;
      fault_q  <= 1'b0;
      large_q  <= 1'b0;
      ent      <= '0;
      ent_addr <= '0;
    end else begin
      case (state)
        IDLE: if (lookup_valid) begin
          va_q    <= lookup_vaddr;
          wr_q    <= lookup_write;
          big_q   <= big_page_en;
          fault_q <= 1'b0;
          large_q <= 1'b0;
          state   <= READ_L1;
        end
        READ_L1: if (mem_ack) begin
          ent      <= mem_rdata;
          ent_addr <= l1_addr;
          if (!mem_rdata[BIT_PRES]) begin
            fault_q <= 1'b1;
            state   <= DONE;
          end else if (big_q && mem_rdata[BIT_BIG]) begin
            large_q <= 1'b1;
            state   <= need_upd ? UPDATE : DONE;
          end else begin
            state   <= READ_L2;
          end
        end
        READ_L2: if (mem_ack) begin
          ent      <= mem_rdata;
          ent_addr <= l2_addr;
          if (!mem_rdata[BIT_PRES]) begin
            fault_q <= 1'b1;
            state   <= DONE;
          end else begin
            state   <= need_upd ? UPDATE : DONE;
          end
        end
        UPDATE: if (mem_ack) begin
          ent   <= mem_wdata;
          state <= DONE;
        end
        default: state <= IDLE;
      endcase
    end
  end

  a_r1_quiet_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !walk_done && !mem_req);

  a_r2_l1_index: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_we && state == READ_L1) |-> mem_addr[11:2] == va_q[31:22]);

  a_r4_large_skips_l2: assert property (@(posedge clk) disable iff (!rst_n)
    (state == READ_L2) |-> !large_q);

  a_r6_fault_zero_addr: assert property (@(posedge clk) disable iff (!rst_n)
    (walk_done && walk_fault) |-> walk_paddr == 32'd0);

  a_r8_load_keeps_dirty: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we && !wr_q) |-> mem_wdata[BIT_DIRTY] == ent[BIT_DIRTY]);

  a_r9_avail_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we) |-> mem_wdata[11:9] == ent[11:9]);

  a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    walk_done |=> !walk_done);

  a_r10_req_held: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> mem_req && $stable(mem_addr) && $stable(mem_we));
endmodule

// File: tb/ptw_two_level_bench.sv
module ptw_two_level_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        lookup_valid = 1'b0;
  logic [31:0] lookup_vaddr = '0;
  logic        lookup_write = 1'b0;
  logic        big_page_en = 1'b0;
  logic [19:0] dir_base = 20'h00100;
  logic        mem_req, mem_we;
  logic [31:0] mem_addr, mem_wdata;
  logic        mem_ack = 1'b0;
  logic [31:0] mem_rdata = '0;
  logic        walk_done, walk_fault;
  logic [31:0] walk_paddr;
  logic [11:0] walk_flags;

  always #2 clk = ~clk;

  ptw_two_level u_ptw_two_level (.*);

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  logic [31:0] mem_model [logic [31:0]];
  int          lat = 0;
  int          n_rd, n_wr, n_done;
  logic [31:0] rd_addr [4];
  logic [31:0] wr_addr, wr_data;
  logic        got_fault;
  logic [31:0] got_paddr;
  logic [11:0] got_flags;

  always @(negedge clk) begin
    cycles++;
    if (mem_ack) mem_ack = 1'b0;
    else if (mem_req) begin
      if (lat == 2) begin
        lat = 0;
        mem_ack = 1'b1;
        if (mem_we) begin
          mem_model[mem_addr] = mem_wdata;
          n_wr++;
          wr_addr = mem_addr;
          wr_data = mem_wdata;
        end else begin
          mem_rdata = mem_model.exists(mem_addr) ? mem_model[mem_addr] : 32'd0;
          if (n_rd < 4) rd_addr[n_rd] = mem_addr;
          n_rd++;
        end
      end else lat++;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] l1a(input logic [31:0] va);
    return {dir_base, va[31:22], 2'b00};
  endfunction
  function automatic logic [31:0] l2a(input logic [31:0] e1, input logic [31:0] va);
    return {e1[31:12], va[21:12], 2'b00};
  endfunction

  task automatic walk(input logic [31:0] va, input bit wr, input bit busy_poke);
    n_rd = 0; n_wr = 0; n_done = 0;
    @(negedge clk);
    lookup_vaddr = va; lookup_write = wr; lookup_valid = 1'b1;
    @(negedge clk);
    lookup_valid = 1'b0;
    for (int i = 0; i < 300; i++) begin
      if (busy_poke && i == 3) begin
        lookup_vaddr = ~va; lookup_write = ~wr; lookup_valid = 1'b1;
      end else if (busy_poke && i == 4) lookup_valid = 1'b0;
      @(negedge clk);
      if (walk_done) begin
        n_done++;
        got_fault = walk_fault; got_paddr = walk_paddr; got_flags = walk_flags;
        break;
      end
    end
    chk(n_done == 1, "R10 walk completes", n_done, 1);
    repeat (6) begin
      @(negedge clk);
      if (walk_done) n_done++;
    end
    chk(n_done == 1, "R10 single done pulse", n_done, 1);
  endtask

  localparam logic [31:0] VA = 32'h0484_5ABC;
  localparam logic [31:0] E1 = 32'h0020_0021;

  task automatic t_small;
    mem_model.delete();
    mem_model[l1a(VA)] = E1;
    mem_model[l2a(E1, VA)] = 32'h1234_5063;
    walk(VA, 1'b0, 1'b0);
    chk(rd_addr[0] == l1a(VA), "R2 first read address", rd_addr[0], l1a(VA));
    chk(rd_addr[1] == l2a(E1, VA), "R3 second read address", rd_addr[1], l2a(E1, VA));
    chk(got_paddr == 32'h1234_5ABC, "R3 small-page result", got_paddr, 32'h1234_5ABC);
    chk(n_wr == 0, "R7 no write when accessed set", n_wr, 0);
    chk(got_flags == 12'h063, "R10 flags out", got_flags, 12'h063);
  endtask

  task automatic t_accessed;
    mem_model.delete();
    mem_model[l1a(VA)] = E1;
    mem_model[l2a(E1, VA)] = 32'h1234_5003;
    walk(VA, 1'b0, 1'b0);
    chk(n_wr == 1 && wr_addr == l2a(E1, VA), "R7 write-back address", wr_addr, l2a(E1, VA));
    chk(wr_data == 32'h1234_5023, "R7 R8 accessed set, dirty untouched on load", wr_data, 32'h1234_5023);
    chk(got_flags == 12'h023, "R10 updated flags out", got_flags, 12'h023);
  endtask

  task automatic t_dirty;
    mem_model.delete();
    mem_model[l1a(VA)] = E1;
    mem_model[l2a(E1, VA)] = 32'h1234_5023;
    walk(VA, 1'b1, 1'b0);
    chk(n_wr == 1 && wr_data == 32'h1234_5063, "R8 store sets dirty", wr_data, 32'h1234_5063);
    walk(VA, 1'b1, 1'b0);
    chk(n_wr == 0, "R8 no write once dirty set", n_wr, 0);
  endtask

  task automatic t_faults;
    mem_model.delete();
    mem_model[l1a(VA)] = 32'h0020_0020;
    walk(VA, 1'b0, 1'b0);
    chk(got_fault && n_rd == 1 && n_wr == 0, "R6 L1 not present", n_rd, 1);
    chk(got_paddr == 0, "R6 fault address zero", got_paddr, 0);
    mem_model[l1a(VA)] = E1;
    mem_model[l2a(E1, VA)] = 32'h1234_5062;
    walk(VA, 1'b1, 1'b0);
    chk(got_fault && n_rd == 2 && n_wr == 0, "R6 L2 not present", n_rd, 2);
  endtask

  task automatic t_large;
    logic [31:0] va2, e1b, eb;
    va2 = 32'h8C1F_3456;
    e1b = 32'hA540_00A1;
    eb  = 32'h7777_7021;
    mem_model.delete();
    mem_model[l1a(va2)] = e1b;
    mem_model[l2a(e1b, va2)] = eb;
    big_page_en = 1'b1;
    walk(va2, 1'b0, 1'b0);
    chk(!got_fault && n_rd == 1, "R4 one read for large page", n_rd, 1);
    chk(got_paddr == {e1b[31:22], va2[21:0]}, "R4 large result", got_paddr, {e1b[31:22], va2[21:0]});
    big_page_en = 1'b0;
    walk(va2, 1'b0, 1'b0);
    chk(n_rd == 2 && rd_addr[1] == l2a(e1b, va2), "R5 strap off reads L2", rd_addr[1], l2a(e1b, va2));
    chk(got_paddr == {eb[31:12], va2[11:0]}, "R5 strap off result", got_paddr, {eb[31:12], va2[11:0]});
  endtask

  task automatic t_ignored;
    mem_model.delete();
    mem_model[l1a(VA)] = 32'h0020_0E21;
    mem_model[l2a(E1, VA)] = 32'h1234_5E01;
    walk(VA, 1'b0, 1'b0);
    chk(got_paddr == 32'h1234_5ABC && !got_fault, "R9 avail bits no effect", got_paddr, 32'h1234_5ABC);
    chk(wr_data == 32'h1234_5E21, "R9 avail bits kept in write-back", wr_data, 32'h1234_5E21);
    chk(got_flags == 12'hE21, "R9 avail bits in flags", got_flags, 12'hE21);
  endtask

  task automatic t_busy;
    mem_model.delete();
    mem_model[l1a(VA)] = E1;
    mem_model[l2a(E1, VA)] = 32'h1234_5063;
    walk(VA, 1'b0, 1'b1);
    chk(n_rd == 2 && got_paddr == 32'h1234_5ABC, "R10 lookup during walk dropped", got_paddr, 32'h1234_5ABC);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!walk_done && !mem_req, "R1 reset state", {walk_done, mem_req}, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(!walk_done && !mem_req, "R1 idle after reset", {walk_done, mem_req}, 0);
    t_small();
    t_accessed();
    t_dirty();
    t_faults();
    t_large();
    t_ignored();
    t_busy();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    wait (cycles >= 100000);
    checks++;
    errors++;
    $display("FAIL watchdog actual=%0d expected=<100000", cycles);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule